// File: doc/BRIEF.md
# Buffered Streaming Program Controller

This block is the device-side sequencer for a streaming, buffer-at-a-time word programming mode of a parallel NOR-style flash. A host enters the mode with a two-write command sequence on a 16-bit write bus. The second write also carries the first-word address of the data stream. The controller then runs a fixed-length startup check of the block lock flag and the programming-voltage flag. If both pass, it accepts a stream of 16-bit words into a 512-word write buffer.

Each time the buffer fills, the controller hands it to an external array-program engine through a start/done handshake. It supplies a block-relative base offset and a random-access read port into the buffer. After a successful commit, the base offset advances by one buffer and wraps inside the block. Once the mode is entered, every write is treated as data, and the read bus always returns the status word. The host leaves the mode by writing to any address other than the held first-word address.

Top module: `stream_prog_ctrl`

## Requirements
- R1: After reset the read bus returns status 0x0080: bit 7 (ready) is set, and the error bits and bit 0 are clear. `arr_start` is low.
- R2: A write whose low byte is 0x80, followed by a write whose low byte is 0xD0 at an address whose low 9 bits are zero, starts the check phase. The check phase lasts SETUP_CYCLES clocks. During it the status reads 0x0001 (bit 7 clear, bit 0 set).
- R3: If the write after 0x80 does not carry 0xD0 in its low byte, status bits 5 and 4 are set (status 0x00B0) and the controller returns to idle.
- R4: At the end of the check phase, a locked block sets bits 4 and 1, and a low programming voltage sets bits 4 and 3. Either fault ends the operation with bit 7 set. Both faults together give 0x009A.
- R5: A confirm write whose address has any of its low 9 bits set ends the operation with status 0x0090.
- R6: While loading, every write to the held first-word address is stored in the buffer as data, including the value 0x0070, and the status stays 0x0000 (bit 7 clear, bit 0 clear = buffer accepting).
- R7: On the 512th stored word the controller raises `arr_start` for exactly one clock, and the status reads 0x0001 until `arr_done`. The array port then reads back the 512 words in arrival order. Writes to the held address during this wait are not stored.
- R8: The first commit's base offset is the first-word address modulo the block size (2^BLK_W words). Each successful commit adds 512, wrapping to offset 0 at the block end. The controller then reloads with status 0x0000.
- R9: An `arr_done` pulse with `arr_fail` high ends the operation with status 0x0090.
- R10: A write to any other address ends the operation. While loading, this takes effect at once (status 0x0080, partial buffer discarded). While a commit is in flight, the status stays 0x0001 until `arr_done` and then becomes 0x0080.
- R11: The suspend request input has no effect in any phase.
- R12: `bus_rdata` always carries the status word in its low byte, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe, one word per clock |
| bus_addr | input | ADDR_W | Word address of the bus write |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Status word, always presented |
| blk_locked | input | 1 | Target block lock flag |
| vpp_ok | input | 1 | Programming voltage at required level |
| susp_req | input | 1 | Suspend request (ignored) |
| arr_start | output | 1 | One-clock commit start pulse |
| arr_base | output | BLK_W | Block-relative word offset of the commit |
| arr_rd_idx | input | log2(BUF_WORDS) | Buffer read index from the array engine |
| arr_rd_data | output | DATA_W | Buffer word at `arr_rd_idx` |
| arr_done | input | 1 | Commit finished pulse |
| arr_fail | input | 1 | Verify failure, qualified by `arr_done` |

## Verification
A wrong phase or a lost error flag shows up in the status word on the read bus at the next clock. The status is a pure function of the registered phase and error bits, so a cycle-by-cycle comparison against a behavioural model catches it within one cycle. A miscounted fill index shows up in one of two ways: `arr_start` arrives a word early or late, or the array engine reads a word out of place at the commit. A wrong base advance or a missing wrap appears on `arr_base` when the next commit starts.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_CHECK,
        ST_LOAD,
        ST_PROG
    } sp_state_e;

    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;

    localparam int SB_READY = 7;
    localparam int SB_SEQ   = 5;
    localparam int SB_PGM   = 4;
    localparam int SB_VOLT  = 3;
    localparam int SB_LOCK  = 1;
    localparam int SB_BUSY  = 0;
endpackage

// File: rtl/sp_cmd_decode.sv
module sp_cmd_decode #(
    parameter int ADDR_W  = 16,
    parameter int ALIGN_W = 9
) (
    input  logic [7:0]        cmd_byte,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] held_addr,
    output logic              is_setup,
    output logic              is_confirm,
    output logic              aligned,
    output logic              addr_match
);
    import sp_pkg::*;

    always_comb begin
        is_setup   = (cmd_byte == CMD_SETUP);
        is_confirm = (cmd_byte == CMD_CONFIRM);
        aligned    = (addr[ALIGN_W-1:0] == '0);
        addr_match = (addr == held_addr);
    end
endmodule

// File: rtl/sp_word_buf.sv
module sp_word_buf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 512,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/sp_fill_track.sv
module sp_fill_track #(
    parameter int DEPTH = 512,
    parameter int BLK_W = 11,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [BLK_W-1:0] init_base,
    input  logic             push,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic [BLK_W-1:0] base,
    output logic             last
);
    localparam logic [BLK_W-1:0] STEP = BLK_W'(DEPTH);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [BLK_W-1:0] base;
    } trk_t;

    trk_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (init) begin
            r_d.idx  = '0;
            r_d.base = init_base;
        end else begin
            if (push) begin
                r_d.idx = r_q.idx + 1'b1;
            end
            if (advance) begin
                r_d.base = r_q.base + STEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idx  = r_q.idx;
    assign base = r_q.base;
    assign last = (r_q.idx == IDX_W'(DEPTH - 1));

    // R7: a push on the last slot wraps the fill index back to zero
    p_wrap_on_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !init && last) |=> (idx == '0));

    // R8: every base offset stays on a buffer boundary
    p_base_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (base[IDX_W-1:0] == '0));
endmodule

// File: rtl/stream_prog_ctrl.sv
module stream_prog_ctrl #(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 16,
    parameter int BUF_WORDS    = 512,
    parameter int BLK_W        = 11,
    parameter int SETUP_CYCLES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic                         blk_locked,
    input  logic                         vpp_ok,
    input  logic                         susp_req,
    output logic                         arr_start,
    output logic [BLK_W-1:0]             arr_base,
    input  logic [$clog2(BUF_WORDS)-1:0] arr_rd_idx,
    output logic [DATA_W-1:0]            arr_rd_data,
    input  logic                         arr_done,
    input  logic                         arr_fail
);
    import sp_pkg::*;

    localparam int IDX_W = $clog2(BUF_WORDS);
    localparam int CNT_W = $clog2(SETUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETUP_CYCLES - 1);

    typedef struct packed {
        sp_state_e         state;
        logic [7:0]        err;
        logic [ADDR_W-1:0] wa0;
        logic [CNT_W-1:0]  cnt;
        logic              exit_pend;
        logic              start;
    } ctl_t;

    ctl_t r_q, r_d;

    logic             is_setup, is_confirm, aligned, addr_match;
    logic             trk_init, trk_push, trk_adv, trk_last;
    logic [IDX_W-1:0] fill_idx;
    logic [7:0]       stat;
    logic             exit_now;

    sp_cmd_decode #(.ADDR_W(ADDR_W), .ALIGN_W(IDX_W)) u_dec (
        .cmd_byte  (bus_wdata[7:0]),
        .addr      (bus_addr),
        .held_addr (r_q.wa0),
        .is_setup  (is_setup),
        .is_confirm(is_confirm),
        .aligned   (aligned),
        .addr_match(addr_match)
    );

    sp_fill_track #(.DEPTH(BUF_WORDS), .BLK_W(BLK_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (trk_init),
        .init_base(r_q.wa0[BLK_W-1:0]),
        .push     (trk_push),
        .advance  (trk_adv),
        .idx      (fill_idx),
        .base     (arr_base),
        .last     (trk_last)
    );

    sp_word_buf #(.DATA_W(DATA_W), .DEPTH(BUF_WORDS)) u_buf (
        .clk    (clk),
        .wr_en  (trk_push),
        .wr_idx (fill_idx),
        .wr_data(bus_wdata),
        .rd_idx (arr_rd_idx),
        .rd_data(arr_rd_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.start = 1'b0;
        trk_init = 1'b0;
        trk_push = 1'b0;
        trk_adv  = 1'b0;
        exit_now = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (bus_we && is_setup) begin
                    r_d.err   = '0;
                    r_d.state = ST_PEND;
                end
            end
            ST_PEND: begin
                if (bus_we) begin
                    if (!is_confirm) begin
                        r_d.err[SB_SEQ] = 1'b1;
                        r_d.err[SB_PGM] = 1'b1;
                        r_d.state       = ST_IDLE;
                    end else if (!aligned) begin
                        r_d.err[SB_PGM] = 1'b1;
                        r_d.state       = ST_IDLE;
                    end else begin
                        r_d.wa0   = bus_addr;
                        r_d.cnt   = '0;
                        r_d.state = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (r_q.cnt == CNT_LAST) begin
                    if (blk_locked) begin
                        r_d.err[SB_LOCK] = 1'b1;
                        r_d.err[SB_PGM]  = 1'b1;
                    end
                    if (!vpp_ok) begin
                        r_d.err[SB_VOLT] = 1'b1;
                        r_d.err[SB_PGM]  = 1'b1;
                    end
                    if (blk_locked || !vpp_ok) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        trk_init  = 1'b1;
                        r_d.state = ST_LOAD;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_LOAD: begin
                if (bus_we) begin
                    if (!addr_match) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        trk_push = 1'b1;
                        if (trk_last) begin
                            r_d.state     = ST_PROG;
                            r_d.start     = 1'b1;
                            r_d.exit_pend = 1'b0;
                        end
                    end
                end
            end
            ST_PROG: begin
                exit_now      = r_q.exit_pend || (bus_we && !addr_match);
                r_d.exit_pend = exit_now;
                if (arr_done) begin
                    r_d.exit_pend = 1'b0;
                    if (arr_fail) begin
                        r_d.err[SB_PGM] = 1'b1;
                        r_d.state       = ST_IDLE;
                    end else begin
                        trk_adv   = 1'b1;
                        r_d.state = exit_now ? ST_IDLE : ST_LOAD;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        stat           = r_q.err;
        stat[SB_READY] = (r_q.state == ST_IDLE) || (r_q.state == ST_PEND);
        stat[SB_BUSY]  = (r_q.state == ST_CHECK) || (r_q.state == ST_PROG);
    end

    assign bus_rdata = DATA_W'(stat);
    assign arr_start = r_q.start;

    // R7: the commit start is a single-clock pulse
    p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |=> !arr_start);

    // R2: status shows busy throughout the check phase
    p_check_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CHECK) |-> (bus_rdata == DATA_W'(8'h01)));

    // R6: loading phase presents ready-for-data status
    p_load_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LOAD) |-> (bus_rdata == '0));

    // R4: a newly raised program error always ends the operation
    p_err_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rdata[SB_PGM]) |-> bus_rdata[SB_READY]);

    // R11: a suspend request with no bus write leaves loading untouched
    p_susp_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_req && !bus_we && r_q.state == ST_LOAD) |=> (r_q.state == ST_LOAD));

    // R12: upper read-bus bits are always zero
    p_rdata_upper_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[DATA_W-1:8] == '0));
endmodule

// File: tb/tb_stream_prog_ctrl.sv
module tb_stream_prog_ctrl;
    localparam int NW = 512;
    localparam int BLK = 2048;
    localparam int SC = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        blk_locked = 0;
    logic        vpp_ok = 1;
    logic        susp_req = 0;
    logic        arr_start;
    logic [10:0] arr_base;
    logic [8:0]  arr_rd_idx = '0;
    logic [15:0] arr_rd_data;
    logic        arr_done = 0;
    logic        arr_fail = 0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit fail_next = 0;
    int last_base = -1;

    always #5 clk = ~clk;

    stream_prog_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .blk_locked(blk_locked),
        .vpp_ok(vpp_ok), .susp_req(susp_req), .arr_start(arr_start),
        .arr_base(arr_base), .arr_rd_idx(arr_rd_idx), .arr_rd_data(arr_rd_data),
        .arr_done(arr_done), .arr_fail(arr_fail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model: 0 idle,1 pend,2 check,3 load,4 prog
    int          m_st = 0;
    int          m_err = 0;
    int          m_cnt = 0;
    int          m_wa0 = 0;
    int          m_idx = 0;
    int          m_base = 0;
    bit          m_exit = 0;
    bit          m_start = 0;
    logic [15:0] m_buf [NW];

    always @(posedge clk) begin
        m_start = 0;
        if (!rst_n) begin
            m_st = 0; m_err = 0; m_exit = 0;
        end else begin
            case (m_st)
                0: if (bus_we && bus_wdata[7:0] == 8'h80) begin m_err = 0; m_st = 1; end
                1: if (bus_we) begin
                    if (bus_wdata[7:0] != 8'hD0) begin m_err = 'h30; m_st = 0; end
                    else if (bus_addr % NW != 0) begin m_err = 'h10; m_st = 0; end
                    else begin m_wa0 = int'(bus_addr); m_cnt = 0; m_st = 2; end
                end
                2: if (m_cnt == SC - 1) begin
                    if (blk_locked) m_err = m_err | 'h12;
                    if (!vpp_ok) m_err = m_err | 'h18;
                    if (m_err != 0) m_st = 0;
                    else begin m_st = 3; m_idx = 0; m_base = m_wa0 % BLK; end
                end else m_cnt++;
                3: if (bus_we) begin
                    if (int'(bus_addr) != m_wa0) m_st = 0;
                    else begin
                        m_buf[m_idx] = bus_wdata;
                        m_idx++;
                        if (m_idx == NW) begin m_idx = 0; m_st = 4; m_start = 1; m_exit = 0; end
                    end
                end
                4: begin
                    if (bus_we && int'(bus_addr) != m_wa0) m_exit = 1;
                    if (arr_done) begin
                        if (arr_fail) begin m_err = 'h10; m_st = 0; end
                        else begin
                            m_base = (m_base + NW) % BLK;
                            m_st = m_exit ? 0 : 3;
                        end
                        m_exit = 0;
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    function automatic int m_status();
        case (m_st)
            0, 1: return 'h80 | m_err;
            2, 4: return 'h01;
            default: return 'h00;
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R12 status vs model", int'(bus_rdata), m_status());
            chk("R7 start vs model", int'(arr_start), int'(m_start));
        end
    end

    // array-program engine model
    initial begin
        forever begin
            @(negedge clk);
            if (arr_start) begin
                chk("R8 base", int'(arr_base), m_base);
                last_base = int'(arr_base);
                for (int i = 0; i < NW; i++) begin
                    arr_rd_idx = 9'(i);
                    #1;
                    chk("R7 buffer word", int'(arr_rd_data), int'(m_buf[i]));
                    @(negedge clk);
                end
                arr_fail = fail_next;
                arr_done = 1;
                @(negedge clk);
                arr_done = 0;
                arr_fail = 0;
            end
        end
    end

    task automatic wr(input int a, input int d);
        bus_we = 1;
        bus_addr = 16'(a);
        bus_wdata = 16'(d);
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic setup(input int a);
        wr(16'h1234, 'h80);
        wr(a, 'hD0);
    endtask

    task automatic wait_check();
        repeat (SC + 2) @(negedge clk);
    endtask

    function automatic int word(input int i, input int tag);
        if (i == 5 || i == 6) return 'h0070;
        if (tag == 2 && i >= NW - 40) return 'hFFFF;
        return (i * 7 + tag * 'h1111) & 'hFFFF;
    endfunction

    task automatic fill(input int a, input int tag, input bit susp);
        for (int i = 0; i < NW; i++) begin
            if (susp) susp_req = i[0];
            wr(a, word(i, tag));
            if (i == 6) chk("R6 0x70 as data", int'(bus_rdata), 'h0000);
        end
        susp_req = 0;
        chk("R7 status after full", int'(bus_rdata), 'h0001);
        chk("R7 start pulse", int'(arr_start), 1);
    endtask

    task automatic wait_done();
        @(posedge arr_done);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset status", int'(bus_rdata), 'h0080);
        chk("R1 reset start", int'(arr_start), 0);
        rst_n = 1;
        @(negedge clk);

        wr(0, 'h80);
        wr(0, 'h55);
        chk("R3 bad confirm", int'(bus_rdata), 'h00B0);

        blk_locked = 1;
        setup('h0400);
        chk("R2 check busy", int'(bus_rdata), 'h0001);
        wait_check();
        chk("R4 locked", int'(bus_rdata), 'h0092);
        blk_locked = 0;
        vpp_ok = 0;
        setup('h0400);
        wait_check();
        chk("R4 low voltage", int'(bus_rdata), 'h0098);
        blk_locked = 1;
        setup('h0400);
        wait_check();
        chk("R4 both faults", int'(bus_rdata), 'h009A);
        blk_locked = 0;
        vpp_ok = 1;

        setup('h0805);
        chk("R5 misaligned", int'(bus_rdata), 'h0090);

        // main stream: offset 0x400 in a 2048-word block
        setup('h1C00);
        wait_check();
        chk("R2 enters load", int'(bus_rdata), 'h0000);
        susp_req = 1;
        repeat (3) @(negedge clk);
        chk("R11 suspend ignored idle", int'(bus_rdata), 'h0000);
        susp_req = 0;
        fill('h1C00, 0, 1);
        chk("R8 first base", last_base, 'h400);
        susp_req = 1;
        wr('h1C00, 'h1234);
        chk("R7 write while busy", int'(bus_rdata), 'h0001);
        chk("R11 suspend during commit", int'(bus_rdata), 'h0001);
        susp_req = 0;
        wait_done();
        chk("R8 reload status", int'(bus_rdata), 'h0000);
        fill('h1C00, 1, 0);
        chk("R8 second base", last_base, 'h600);
        wait_done();
        fill('h1C00, 2, 0);
        chk("R8 wrapped base", last_base, 'h000);
        wait_done();
        chk("R8 after wrap", int'(bus_rdata), 'h0000);
        for (int i = 0; i < 10; i++) wr('h1C00, i);
        wr('h1C01, 0);
        chk("R10 exit in load", int'(bus_rdata), 'h0080);

        // exit during commit
        setup('h0000);
        wait_check();
        fill('h0000, 3, 0);
        wr('h0001, 0);
        chk("R10 exit waits commit", int'(bus_rdata), 'h0001);
        wait_done();
        chk("R10 exit after commit", int'(bus_rdata), 'h0080);

        // verify failure
        setup('h0200);
        wait_check();
        fail_next = 1;
        fill('h0200, 4, 0);
        wait_done();
        fail_next = 0;
        chk("R9 verify fail", int'(bus_rdata), 'h0090);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule